// File: doc/BRIEF.md
# Floppy Drive Control Output Register

This block is the byte-wide control register that a host writes to steer the drive interface of a floppy disk controller. It answers at one I/O address, accepts a write at any time and can be read back. The stored byte turns into four motor-on lines, a one-hot drive-select bus decoded from a two-bit drive number, and an internal soft-reset level for the rest of the controller. That level stays up for as long as the run bit is clear, and it is stretched so that every reset pulse is at least a minimum width. The soft reset never clears the register that produces it.

The block also gates the controller's DMA and interrupt signals. In AT-compatible mode the DMA-enable bit decides whether the request and interrupt outputs drive their tri-state pins and whether the acknowledge and terminal-count inputs reach the core. In PS/2 mode those four signals are always live, hardware reset included, although a hardware reset still clears the enable bit.

Top module: `fdc_drive_ctl_reg`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, the stored byte is 0x00, `motor_o` is 0, `ds_o` is 4'b0001 and `soft_rst_o` is 1.
- R2: A write (`wr_en_i` high with `addr_i` equal to `REG_ADDR`, default 0x3F2) stores `wr_data_i` at the next clock edge. A read at that address puts the stored byte on `rd_data_o` with `rd_oe_o` high for the following cycle only. Otherwise `rd_oe_o` is 0 and `rd_data_o` is 0x00.
- R3: A write or read at any other address changes nothing and leaves `rd_oe_o` low.
- R4: Byte bits 1:0 hold drive number n. `ds_o` has exactly bit n set.
- R5: `motor_o[i]` equals byte bit 4+i.
- R6: Byte bit 2 is the run bit. While it is 0, `soft_rst_o` is 1. The soft reset leaves every stored bit intact, so a read returns the byte last written.
- R7: A write that clears the run bit raises `soft_rst_o` for at least `RST_MIN_CYC` cycles (default 3), starting in the cycle after that write. A clearing write followed in the very next cycle by a setting write yields a pulse of exactly `RST_MIN_CYC` cycles.
- R8: With `ps2_mode_i` 0 and byte bit 3 (DMA enable) 0, `drq_oe_o` and `irq_oe_o` are 0, `drq_o` and `irq_o` are 0, `tc_core_o` is 0 and `dack_n_core_o` is 1, whatever the inputs.
- R9: With `ps2_mode_i` 0 and bit 3 set, both output enables are 1 and the request, interrupt, acknowledge and terminal-count signals pass unchanged.
- R10: With `ps2_mode_i` 1, the four signals pass and both output enables are 1 at all times, also during hardware reset. Hardware reset still reads back bit 3 as 0.
- R11: Writing 0x1C, 0x2D, 0x4E or 0x8F selects drive 0, 1, 2 or 3. Only that drive's motor is on, DMA is enabled and `soft_rst_o` is 0.
- R12: When a read and a write hit in the same cycle, the read returns the byte held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| addr_i | input | ADDR_W | I/O address |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, valid the cycle after a read hit |
| rd_oe_o | output | 1 | Data bus drive enable for read data |
| ps2_mode_i | input | 1 | 1 = PS/2 mode, 0 = AT-compatible mode |
| ds_o | output | 4 | One-hot drive select, active high |
| motor_o | output | 4 | Motor on per drive, active high |
| soft_rst_o | output | 1 | Controller soft reset level |
| drq_core_i | input | 1 | DMA request from the core |
| drq_o | output | 1 | DMA request to the pin |
| drq_oe_o | output | 1 | Output enable of the DMA request pin |
| irq_core_i | input | 1 | Interrupt from the core |
| irq_o | output | 1 | Interrupt to the pin |
| irq_oe_o | output | 1 | Output enable of the interrupt pin |
| dack_n_i | input | 1 | DMA acknowledge from the pin, active low |
| dack_n_core_o | output | 1 | Gated DMA acknowledge to the core, active low |
| tc_i | input | 1 | Terminal count from the pin |
| tc_core_o | output | 1 | Gated terminal count to the core |

## Verification
Two pairs of functions can fall in the same cycle. The first is a read and a write to the register in one strobe cycle. The bench issues both with different old and new bytes, expects the old byte on the read port, and then reads again to find the new byte. The second is the soft-reset stretch meeting an early release: a run-clearing write is followed at once by a run-setting write, and the bench counts the high cycles of `soft_rst_o` against the minimum width while the stored byte already shows the run bit set.

// File: rtl/fdc_dcr_pkg.sv
// Package: shared widths, bit positions and the register layout for the
// drive control register. Assumes an 8-bit register serving four drives.
package fdc_dcr_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_DRV  = 4;
    localparam int SEL_W    = $clog2(NUM_DRV);

    // Bit positions that the rest of the controller depends on.
    localparam int BIT_RUN  = 2;
    localparam int BIT_DMA  = 3;
    localparam int BIT_MOT0 = 4;

    typedef struct packed {
        logic [NUM_DRV-1:0] motor;   // bits 7:4, one per drive
        logic               dma_en;  // bit 3
        logic               run;     // bit 2, 0 holds the controller in reset
        logic [SEL_W-1:0]   drv;     // bits 1:0, binary drive number
    } ctl_t;
endpackage

// File: rtl/fdc_dcr_store.sv
// Module: holds the control byte and serves the registered read path.
// Assumes the write and read hits are already address-qualified.
// A read returns the byte held before any write in the same cycle.
module fdc_dcr_store
    import fdc_dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_t              ctl_q,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_oe_o
);
    // Control byte: cleared by hardware reset only, loaded on a write hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_hit) begin
            ctl_q <= ctl_t'(wr_data);
        end
    end

    // Read port: one cycle of data and bus enable after a read hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
            rd_oe_o   <= 1'b0;
        end else begin
            rd_data_o <= rd_hit ? DATA_W'(ctl_q) : '0;
            rd_oe_o   <= rd_hit;
        end
    end
endmodule

// File: rtl/fdc_soft_rst_gen.sv
// Module: produces the controller soft-reset level from the run bit.
// Each write that clears the run bit starts a hold counter so that the
// pulse lasts at least MIN_CYC cycles, even when the run bit is set again
// in the next cycle. Assumes MIN_CYC >= 1.
module fdc_soft_rst_gen #(
    parameter int MIN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic run_wr,   // run bit carried by the current write
    input  logic run_q,    // stored run bit
    output logic soft_rst_o
);
    localparam int CNT_W = $clog2(MIN_CYC + 1);

    logic [CNT_W-1:0] hold_q;

    // Hold counter: loaded on a clearing write, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_hit && !run_wr) begin
            hold_q <= CNT_W'(MIN_CYC);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    // Reset level: run bit low or minimum width not yet reached.
    always_comb begin
        soft_rst_o = !run_q || (hold_q != '0);
    end
endmodule

// File: rtl/fdc_drive_decode.sv
// Module: turns the drive number into a one-hot select and passes the
// motor bits out. Purely combinational; assumes a settled control byte.
module fdc_drive_decode
    import fdc_dcr_pkg::*;
(
    input  ctl_t               ctl,
    output logic [NUM_DRV-1:0] ds_o,
    output logic [NUM_DRV-1:0] motor_o
);
    // One comparator per drive-select line.
    for (genvar g = 0; g < NUM_DRV; g++) begin : g_sel
        always_comb begin
            ds_o[g] = (ctl.drv == SEL_W'(g));
        end
    end

    // Motor lines follow their bits directly.
    always_comb begin
        motor_o = ctl.motor;
    end
endmodule

// File: rtl/fdc_dma_gate.sv
// Module: gates DMA request, acknowledge, terminal count and interrupt.
// AT-compatible mode enables them only with the DMA enable bit; PS/2 mode
// enables them always. A disabled output is held low with its enable low;
// a disabled input is forced to its inactive level.
module fdc_dma_gate (
    input  logic ps2_mode,
    input  logic dma_en,
    input  logic drq_core_i,
    input  logic irq_core_i,
    input  logic dack_n_i,
    input  logic tc_i,
    output logic drq_o,
    output logic drq_oe_o,
    output logic irq_o,
    output logic irq_oe_o,
    output logic dack_n_core_o,
    output logic tc_core_o
);
    logic live;

    // Mode select: PS/2 overrides the enable bit.
    always_comb begin
        live = ps2_mode || dma_en;
    end

    // Signal gating toward the pins and toward the core.
    always_comb begin
        drq_o         = drq_core_i && live;
        drq_oe_o      = live;
        irq_o         = irq_core_i && live;
        irq_oe_o      = live;
        dack_n_core_o = dack_n_i || !live;
        tc_core_o     = tc_i && live;
    end
endmodule

// File: rtl/fdc_drive_ctl_reg.sv
// Module: top of the drive control register. Decodes the I/O address,
// stores the byte, and drives drive select, motors, soft reset and the
// DMA/interrupt gating. Assumes single-cycle strobes from the host bus.
module fdc_drive_ctl_reg
    import fdc_dcr_pkg::*;
#(
    parameter int          ADDR_W      = 10,
    parameter logic [9:0]  REG_ADDR    = 10'h3F2,
    parameter int          RST_MIN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        rd_data_o,
    output logic              rd_oe_o,
    input  logic              ps2_mode_i,
    output logic [3:0]        ds_o,
    output logic [3:0]        motor_o,
    output logic              soft_rst_o,
    input  logic              drq_core_i,
    output logic              drq_o,
    output logic              drq_oe_o,
    input  logic              irq_core_i,
    output logic              irq_o,
    output logic              irq_oe_o,
    input  logic              dack_n_i,
    output logic              dack_n_core_o,
    input  logic              tc_i,
    output logic              tc_core_o
);
    logic addr_match;
    logic wr_hit;
    logic rd_hit;
    ctl_t ctl_q;

    // Address decode and strobe qualification.
    always_comb begin
        addr_match = (addr_i == ADDR_W'(REG_ADDR));
        wr_hit     = wr_en_i && addr_match;
        rd_hit     = rd_en_i && addr_match;
    end

    fdc_dcr_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit),
        .wr_data   (wr_data_i),
        .ctl_q     (ctl_q),
        .rd_data_o (rd_data_o),
        .rd_oe_o   (rd_oe_o)
    );

    fdc_soft_rst_gen #(
        .MIN_CYC (RST_MIN_CYC)
    ) u_srst (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .run_wr     (wr_data_i[BIT_RUN]),
        .run_q      (ctl_q.run),
        .soft_rst_o (soft_rst_o)
    );

    fdc_drive_decode u_dec (
        .ctl     (ctl_q),
        .ds_o    (ds_o),
        .motor_o (motor_o)
    );

    fdc_dma_gate u_gate (
        .ps2_mode      (ps2_mode_i),
        .dma_en        (ctl_q.dma_en),
        .drq_core_i    (drq_core_i),
        .irq_core_i    (irq_core_i),
        .dack_n_i      (dack_n_i),
        .tc_i          (tc_i),
        .drq_o         (drq_o),
        .drq_oe_o      (drq_oe_o),
        .irq_o         (irq_o),
        .irq_oe_o      (irq_oe_o),
        .dack_n_core_o (dack_n_core_o),
        .tc_core_o     (tc_core_o)
    );
endmodule

// File: rtl/fdc_drive_ctl_reg_chk.sv
// Module: assertion checker for fdc_drive_ctl_reg, attached by bind.
// Observes ports and the stored byte; drives nothing.
module fdc_drive_ctl_reg_chk #(
    parameter int         ADDR_W   = 10,
    parameter logic [9:0] REG_ADDR = 10'h3F2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [7:0]        wr_data_i,
    input logic [7:0]        rd_data_o,
    input logic              rd_oe_o,
    input logic              ps2_mode_i,
    input logic [7:0]        ctl_q,
    input logic [3:0]        ds_o,
    input logic [3:0]        motor_o,
    input logic              soft_rst_o,
    input logic              drq_oe_o,
    input logic              irq_oe_o,
    input logic              dack_n_core_o,
    input logic              tc_core_o
);
    logic wr_hit_c;
    logic rd_hit_c;

    // Independent decode of the strobes.
    always_comb begin
        wr_hit_c = wr_en_i && (addr_i == ADDR_W'(REG_ADDR));
        rd_hit_c = rd_en_i && (addr_i == ADDR_W'(REG_ADDR));
    end

    // R1: hardware reset clears the byte and asserts soft reset.
    a_r1_hw_reset: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == 8'h00) && soft_rst_o);

    // R2: a read hit presents the byte held at the strobe.
    a_r2_read_back: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_c |=> rd_oe_o && (rd_data_o == $past(ctl_q)));

    // R3: without a write hit the byte stays put.
    a_r3_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit_c |=> $stable(ctl_q));

    // R4: exactly one drive-select line.
    a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ds_o) == 1);

    // R5: motors follow the written nibble.
    a_r5_motor_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_c |=> motor_o == $past(wr_data_i[7:4]));

    // R6: a write clearing the run bit asserts soft reset.
    a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_c && !wr_data_i[2]) |=> soft_rst_o);

    // R8: AT mode with DMA disabled keeps pins off and inputs inactive.
    a_r8_at_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps2_mode_i && !ctl_q[3]) |-> (!drq_oe_o && !irq_oe_o && !tc_core_o && dack_n_core_o));

    // R9: AT mode with DMA enabled drives both pins.
    a_r9_at_live: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps2_mode_i && ctl_q[3]) |-> (drq_oe_o && irq_oe_o));

    // R10: PS/2 mode keeps both pins enabled, even in hardware reset.
    a_r10_ps2_live: assert property (@(posedge clk)
        ps2_mode_i |-> (drq_oe_o && irq_oe_o));
endmodule

bind fdc_drive_ctl_reg fdc_drive_ctl_reg_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_i        (addr_i),
    .wr_en_i       (wr_en_i),
    .rd_en_i       (rd_en_i),
    .wr_data_i     (wr_data_i),
    .rd_data_o     (rd_data_o),
    .rd_oe_o       (rd_oe_o),
    .ps2_mode_i    (ps2_mode_i),
    .ctl_q         (ctl_q),
    .ds_o          (ds_o),
    .motor_o       (motor_o),
    .soft_rst_o    (soft_rst_o),
    .drq_oe_o      (drq_oe_o),
    .irq_oe_o      (irq_oe_o),
    .dack_n_core_o (dack_n_core_o),
    .tc_core_o     (tc_core_o)
);

// File: tb/tb_fdc_drive_ctl_reg.sv
// Directed bench for fdc_drive_ctl_reg: one task per scenario.
// Inputs change and outputs are sampled on the falling clock edge.
module tb_fdc_drive_ctl_reg;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_CYC    = 3;
    localparam logic [9:0] RADDR = 10'h3F2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] addr_i = '0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic       rd_oe_o;
    logic       ps2_mode_i = 1'b0;
    logic [3:0] ds_o;
    logic [3:0] motor_o;
    logic       soft_rst_o;
    logic       drq_core_i = 1'b0;
    logic       drq_o;
    logic       drq_oe_o;
    logic       irq_core_i = 1'b0;
    logic       irq_o;
    logic       irq_oe_o;
    logic       dack_n_i = 1'b1;
    logic       dack_n_core_o;
    logic       tc_i = 1'b0;
    logic       tc_core_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_drive_ctl_reg #(
        .ADDR_W(10), .REG_ADDR(RADDR), .RST_MIN_CYC(MIN_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .rd_oe_o(rd_oe_o), .ps2_mode_i(ps2_mode_i), .ds_o(ds_o),
        .motor_o(motor_o), .soft_rst_o(soft_rst_o), .drq_core_i(drq_core_i),
        .drq_o(drq_o), .drq_oe_o(drq_oe_o), .irq_core_i(irq_core_i),
        .irq_o(irq_o), .irq_oe_o(irq_oe_o), .dack_n_i(dack_n_i),
        .dack_n_core_o(dack_n_core_o), .tc_i(tc_i), .tc_core_o(tc_core_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rd_data_o; oe = rd_oe_o;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic oe;
        rst_n = 1'b0; idle(3);
        chk("R1 motors", 32'(motor_o), 32'h0);
        chk("R1 select", 32'(ds_o), 32'h1);
        chk("R1 soft reset", 32'(soft_rst_o), 32'h1);
        rst_n = 1'b1;
        rd(RADDR, d, oe);
        chk("R1 byte", 32'(d), 32'h00);
        chk("R2 idle oe", 32'(rd_oe_o), 32'h1);
        idle(1);
        chk("R2 oe drops", 32'(rd_oe_o), 32'h0);
        chk("R2 data idle", 32'(rd_data_o), 32'h0);
    endtask

    task automatic t_write_read();
        logic [7:0] d; logic oe;
        wr(RADDR, 8'hA5);
        rd(RADDR, d, oe);
        chk("R2 readback", 32'(d), 32'hA5);
        chk("R2 read oe", 32'(oe), 32'h1);
    endtask

    task automatic t_foreign();
        logic [7:0] d; logic oe;
        wr(RADDR, 8'h35);
        wr(10'h3F4, 8'hC2);
        wr(10'h1F2, 8'hFF);
        chk("R3 motors kept", 32'(motor_o), 32'h3);
        rd(10'h3F3, d, oe);
        chk("R3 foreign read oe", 32'(oe), 32'h0);
        rd(RADDR, d, oe);
        chk("R3 byte kept", 32'(d), 32'h35);
    endtask

    task automatic t_select_motor();
        for (int n = 0; n < 4; n++) begin
            wr(RADDR, 8'(n) | 8'h04);
            chk("R4 one-hot", 32'(ds_o), 32'(1 << n));
        end
        for (int m = 0; m < 16; m += 5) begin
            wr(RADDR, 8'(m << 4) | 8'h04);
            chk("R5 motors", 32'(motor_o), 32'(m));
        end
    endtask

    task automatic t_level();
        logic [7:0] d; logic oe;
        wr(RADDR, 8'hF3);
        idle(8);
        chk("R6 held", 32'(soft_rst_o), 32'h1);
        rd(RADDR, d, oe);
        chk("R6 byte intact", 32'(d), 32'hF3);
        wr(RADDR, 8'hF7);
        chk("R6 released", 32'(soft_rst_o), 32'h0);
        chk("R6 motors intact", 32'(motor_o), 32'hF);
    endtask

    task automatic t_pulse();
        int high;
        wr(RADDR, 8'h1C);
        idle(MIN_CYC + 2);
        chk("R7 quiet before", 32'(soft_rst_o), 32'h0);
        @(negedge clk);
        addr_i = RADDR; wr_data_i = 8'h18; wr_en_i = 1'b1;
        @(negedge clk);
        wr_data_i = 8'h1C;
        high = soft_rst_o ? 1 : 0;
        @(negedge clk);
        wr_en_i = 1'b0;
        while (soft_rst_o && high < 20) begin
            high++;
            @(negedge clk);
        end
        chk("R7 pulse width", 32'(high), 32'(MIN_CYC));
        chk("R7 run bit set", 32'(soft_rst_o), 32'h0);
    endtask

    task automatic t_at();
        ps2_mode_i = 1'b0;
        wr(RADDR, 8'h14);
        drq_core_i = 1'b1; irq_core_i = 1'b1; dack_n_i = 1'b0; tc_i = 1'b1;
        #1;
        chk("R8 oe", 32'({drq_oe_o, irq_oe_o}), 32'h0);
        chk("R8 outputs", 32'({drq_o, irq_o}), 32'h0);
        chk("R8 inputs", 32'({dack_n_core_o, tc_core_o}), 32'h2);
        wr(RADDR, 8'h1C);
        #1;
        chk("R9 oe", 32'({drq_oe_o, irq_oe_o}), 32'h3);
        chk("R9 pass", 32'({drq_o, irq_o, dack_n_core_o, tc_core_o}), 32'hD);
        drq_core_i = 1'b0; irq_core_i = 1'b0; dack_n_i = 1'b1; tc_i = 1'b0;
        #1;
        chk("R9 pass low", 32'({drq_o, irq_o, dack_n_core_o, tc_core_o}), 32'h2);
    endtask

    task automatic t_ps2();
        logic [7:0] d; logic oe;
        ps2_mode_i = 1'b1;
        wr(RADDR, 8'h1C);
        rst_n = 1'b0;
        idle(2);
        drq_core_i = 1'b1; dack_n_i = 1'b0; tc_i = 1'b1;
        #1;
        chk("R10 oe in reset", 32'({drq_oe_o, irq_oe_o}), 32'h3);
        chk("R10 pass in reset", 32'({drq_o, dack_n_core_o, tc_core_o}), 32'h5);
        rst_n = 1'b1;
        rd(RADDR, d, oe);
        chk("R10 dma bit cleared", 32'(d[3]), 32'h0);
        wr(RADDR, 8'h14);
        #1;
        chk("R10 dma off still live", 32'({drq_oe_o, irq_oe_o, tc_core_o}), 32'h7);
        drq_core_i = 1'b0; dack_n_i = 1'b1; tc_i = 1'b0;
        ps2_mode_i = 1'b0;
    endtask

    task automatic t_presets();
        logic [7:0] v;
        for (int n = 0; n < 4; n++) begin
            v = 8'((1 << (n + 4)) | 8'h0C | n);
            wr(RADDR, v);
            chk("R11 select", 32'(ds_o), 32'(1 << n));
            chk("R11 motor", 32'(motor_o), 32'(1 << n));
            chk("R11 dma and run", 32'({drq_oe_o, soft_rst_o}), 32'h2);
        end
    endtask

    task automatic t_collide();
        logic [7:0] d; logic oe;
        wr(RADDR, 8'h1C);
        @(negedge clk);
        addr_i = RADDR; wr_data_i = 8'h2D; wr_en_i = 1'b1; rd_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; rd_en_i = 1'b0;
        chk("R12 old byte", 32'(rd_data_o), 32'h1C);
        rd(RADDR, d, oe);
        chk("R12 new byte", 32'(d), 32'h2D);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_write_read();
        t_foreign();
        t_select_motor();
        t_level();
        t_pulse();
        t_at();
        t_ps2();
        t_presets();
        t_collide();
        idle(2);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule